// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

The block gathers sixteen interrupt sources for a small processor core. Each source delivers a one-cycle event pulse. The event is recorded in a pending register. A mask register and a global enable flag decide which pending sources may be serviced. The core drives a 3-bit command code, with a 16-bit data word, to read, write and clear the pending register, to read and write the mask, and to turn the global enable on or off.

Whenever a pending source is eligible, the block raises a service request and presents that source's vector address. When the core accepts the request at an instruction boundary, the block pulses a strobe that tells the core to copy its instruction counter into a save register. The core then loads the vector address as its new instruction counter, and the block drops the global enable.

Two sources, power-fail and software interrupt, are always eligible. Every other source is still recorded while it is disabled or masked, but it is not serviced.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset the pending register, the mask register and the global enable are all zero, and no service request is raised.
- R2: Command 6 sets the global enable and command 7 clears it. The change is seen from the next rising clock edge, and the data word is ignored. The status word carries the enable in bit 9; all its other bits are zero.
- R3: An event pulse on source n sets pending bit n only if that bit was 0 before the edge. A bit that is already 1 is not re-latched, so a same-cycle write of 0 leaves it at 0.
- R4: Command 1 returns the pending register and command 4 returns the mask on the read data port in the same cycle. Every other command gives zero on that port.
- R5: Command 2 loads the pending register from the data word. Command 3 clears the pending bits where the data word has ones and keeps the rest. When command 3 and an event hit the same bit in the same cycle, the bit ends at 1.
- R6: Command 5 loads the mask. A mask bit of 0 blocks service of its source, and 0xFFFF lets every source through.
- R7: Source 0 (power-fail) and source 2 (software interrupt) are serviced while the global enable is 0 and while their mask bit is 0.
- R8: Among the eligible pending sources, the lowest index wins. The vector address is 0x400 + 4·n, which spans 0x400 to 0x43C.
- R9: When the core asserts the accept input while a request is raised, the save strobe is high in that cycle, and the global enable is 0 after the edge. Service entry takes precedence over an enable command in the same cycle.
- R10: If the enable is set, or a source is unmasked, while its pending bit is already 1, the request appears in the cycle after the command edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| evtPulse | input | 16 | One-cycle event pulse per source |
| cmdOp | input | 3 | Command code, 0 = no operation |
| cmdData | input | 16 | Data word for write, clear and mask commands |
| svcTake | input | 1 | Core accepts the current service request |
| rdData | output | 16 | Value returned by the read commands |
| statusWord | output | 16 | Status word, global enable in bit 9 |
| svcReq | output | 1 | An eligible pending interrupt exists |
| vecAddr | output | 16 | Vector address of the winning source |
| saveIcStb | output | 1 | Strobe to copy the instruction counter into the save register |

## Verification
The assertions assume that the command code and the accept input are known (never X) on every clock edge after reset, and that the accept input is only meaningful when a request is raised. The stimulus drives every input on the falling edge from a table or from directed steps. It never leaves an input undriven, and it raises accept only in steps where a request is expected, so that each entry has a predictable vector. The corner cases are placed so that they are resolved by the state of a single cycle: a clear and an event on the same bit, a write and an event on a set bit, and an enable command together with service entry.

// File: rtl/vic_pkg.sv
package vic_pkg;

  typedef enum logic [2:0] {
    OP_NOP      = 3'd0,
    OP_RD_PEND  = 3'd1,
    OP_WR_PEND  = 3'd2,
    OP_CLR_PEND = 3'd3,
    OP_RD_MASK  = 3'd4,
    OP_WR_MASK  = 3'd5,
    OP_EN       = 3'd6,
    OP_DIS      = 3'd7
  } cmdOpT;

  typedef struct packed {
    logic wrPend;
    logic clrPend;
    logic wrMask;
    logic setEn;
    logic clrEn;
    logic enter;
    logic rdPend;
    logic rdMask;
  } strobeT;

endpackage

// File: rtl/vic_datapath.sv
module vic_datapath
  import vic_pkg::*;
#(
  parameter int N_SRC  = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            stb,
  input  logic [N_SRC-1:0]  evtPulse,
  input  logic [DATA_W-1:0] cmdData,
  output logic [N_SRC-1:0]  pendQ,
  output logic [N_SRC-1:0]  maskQ,
  output logic              enQ,
  output logic [DATA_W-1:0] rdData
);

  // one pending cell per source
  for (genvar i = 0; i < N_SRC; i++) begin : g_pend
    logic baseBit;
    logic canLatch;
    always_comb begin
      baseBit = pendQ[i];
      if (stb.wrPend)       baseBit = cmdData[i];
      else if (stb.clrPend) baseBit = pendQ[i] & ~cmdData[i];
      // latch only into a bit that was 0, or one being cleared now
      canLatch = ~pendQ[i] | (stb.clrPend & cmdData[i]);
    end
    always_ff @(posedge clk) begin
      if (!rstN) pendQ[i] <= 1'b0;
      else       pendQ[i] <= baseBit | (evtPulse[i] & canLatch);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)           maskQ <= '0;
    else if (stb.wrMask) maskQ <= cmdData[N_SRC-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN)          enQ <= 1'b0;
    else if (stb.enter) enQ <= 1'b0;
    else if (stb.setEn) enQ <= 1'b1;
    else if (stb.clrEn) enQ <= 1'b0;
  end

  always_comb begin
    rdData = '0;
    if (stb.rdPend)      rdData = DATA_W'(pendQ);
    else if (stb.rdMask) rdData = DATA_W'(maskQ);
  end

endmodule

// File: rtl/vic_ctrl.sv
module vic_ctrl
  import vic_pkg::*;
#(
  parameter int                N_SRC      = 16,
  parameter int                ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] VEC_BASE   = 16'h0400,
  parameter int                VEC_STRIDE = 4,
  parameter int                PFAIL_SRC  = 0,
  parameter int                SWI_SRC    = 2
) (
  input  logic [2:0]        cmdOp,
  input  logic              svcTake,
  input  logic [N_SRC-1:0]  pendQ,
  input  logic [N_SRC-1:0]  maskQ,
  input  logic              enQ,
  output strobeT            stb,
  output logic              svcReq,
  output logic [ADDR_W-1:0] vecAddr,
  output logic              saveIcStb
);

  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;
  localparam logic [N_SRC-1:0] EXEMPT =
    (N_SRC'(1) << PFAIL_SRC) | (N_SRC'(1) << SWI_SRC);

  cmdOpT            op;
  logic [N_SRC-1:0] eligible;
  logic [IDX_W-1:0] winIdx;

  assign op       = cmdOpT'(cmdOp);
  assign eligible = pendQ & ((maskQ & {N_SRC{enQ}}) | EXEMPT);
  assign svcReq   = |eligible;

  // fixed priority: the lowest index wins
  always_comb begin
    winIdx = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (eligible[i]) winIdx = IDX_W'(i);
    end
  end

  assign vecAddr   = VEC_BASE + ADDR_W'(winIdx) * ADDR_W'(VEC_STRIDE);
  assign saveIcStb = svcReq & svcTake;

  always_comb begin
    stb         = '0;
    stb.wrPend  = (op == OP_WR_PEND);
    stb.clrPend = (op == OP_CLR_PEND);
    stb.wrMask  = (op == OP_WR_MASK);
    stb.setEn   = (op == OP_EN);
    stb.clrEn   = (op == OP_DIS);
    stb.rdPend  = (op == OP_RD_PEND);
    stb.rdMask  = (op == OP_RD_MASK);
    stb.enter   = saveIcStb;
  end

endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import vic_pkg::*;
#(
  parameter int N_SRC       = 16,
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 16,
  parameter int STAT_W      = 16,
  parameter int STAT_EN_BIT = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [N_SRC-1:0]  evtPulse,
  input  logic [2:0]        cmdOp,
  input  logic [DATA_W-1:0] cmdData,
  input  logic              svcTake,
  output logic [DATA_W-1:0] rdData,
  output logic [STAT_W-1:0] statusWord,
  output logic              svcReq,
  output logic [ADDR_W-1:0] vecAddr,
  output logic              saveIcStb
);

  strobeT           stb;
  logic [N_SRC-1:0] pendQ;
  logic [N_SRC-1:0] maskQ;
  logic             enQ;

  vic_ctrl #(
    .N_SRC(N_SRC), .ADDR_W(ADDR_W)
  ) u_ctrl (
    .cmdOp(cmdOp), .svcTake(svcTake), .pendQ(pendQ), .maskQ(maskQ),
    .enQ(enQ), .stb(stb), .svcReq(svcReq), .vecAddr(vecAddr),
    .saveIcStb(saveIcStb)
  );

  vic_datapath #(
    .N_SRC(N_SRC), .DATA_W(DATA_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .evtPulse(evtPulse),
    .cmdData(cmdData), .pendQ(pendQ), .maskQ(maskQ), .enQ(enQ),
    .rdData(rdData)
  );

  assign statusWord = STAT_W'(enQ) << STAT_EN_BIT;

endmodule

// File: rtl/vec_irq_chk.sv
module vec_irq_chk #(
  parameter int STAT_W      = 16,
  parameter int STAT_EN_BIT = 9
) (
  input logic              clk,
  input logic              rstN,
  input logic [2:0]        cmdOp,
  input logic              svcTake,
  input logic [15:0]       rdData,
  input logic [STAT_W-1:0] statusWord,
  input logic              svcReq,
  input logic [15:0]       vecAddr,
  input logic              saveIcStb
);

  // R9: service entry drops the global enable
  a_r9_entry_clears_en: assert property (@(posedge clk) disable iff (!rstN)
    saveIcStb |=> !statusWord[STAT_EN_BIT]);

  // R2: enable command takes effect at the next edge
  a_r2_enable_cmd: assert property (@(posedge clk) disable iff (!rstN)
    (cmdOp == 3'd6 && !saveIcStb) |=> statusWord[STAT_EN_BIT]);

  // R2: disable command takes effect at the next edge
  a_r2_disable_cmd: assert property (@(posedge clk) disable iff (!rstN)
    (cmdOp == 3'd7) |=> !statusWord[STAT_EN_BIT]);

  // R2: without a command or an entry the status holds
  a_r2_status_holds: assert property (@(posedge clk) disable iff (!rstN)
    (cmdOp < 3'd6 && !saveIcStb) |=> $stable(statusWord));

  // R8: vector lies in the table and is word-aligned to four
  a_r8_vec_range: assert property (@(posedge clk) disable iff (!rstN)
    svcReq |-> (vecAddr >= 16'h0400 && vecAddr <= 16'h043C && vecAddr[1:0] == 2'b00));

  // R4: non-read commands return zero
  a_r4_rd_idle: assert property (@(posedge clk) disable iff (!rstN)
    (cmdOp != 3'd1 && cmdOp != 3'd4) |-> (rdData == 16'h0000));

  // R9: the strobe appears only with accept
  a_r9_strobe_needs_take: assert property (@(posedge clk) disable iff (!rstN)
    saveIcStb |-> svcTake);

endmodule

bind vec_irq_ctrl vec_irq_chk #(
  .STAT_W(STAT_W), .STAT_EN_BIT(STAT_EN_BIT)
) u_chk (
  .clk(clk), .rstN(rstN), .cmdOp(cmdOp), .svcTake(svcTake),
  .rdData(rdData), .statusWord(statusWord), .svcReq(svcReq),
  .vecAddr(vecAddr), .saveIcStb(saveIcStb)
);

// File: tb/sim_vec_irq_ctrl.sv
module sim_vec_irq_ctrl;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] evtPulse = '0;
  logic [2:0]  cmdOp = '0;
  logic [15:0] cmdData = '0;
  logic        svcTake = 1'b0;
  logic [15:0] rdData;
  logic [15:0] statusWord;
  logic        svcReq;
  logic [15:0] vecAddr;
  logic        saveIcStb;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  vec_irq_ctrl u0 (
    .clk(clk), .rstN(rstN), .evtPulse(evtPulse), .cmdOp(cmdOp),
    .cmdData(cmdData), .svcTake(svcTake), .rdData(rdData),
    .statusWord(statusWord), .svcReq(svcReq), .vecAddr(vecAddr),
    .saveIcStb(saveIcStb)
  );

  typedef struct packed {
    logic [15:0] evt;
    logic [2:0]  op;
    logic [15:0] data;
    logic        take;
    logic [15:0] expRd;
    logic        expReq;
    logic [15:0] expVec;
    logic        expEn;
    logic        expSave;
  } rowT;

  // ops: 0 nop 1 rdPend 2 wrPend 3 clrPend 4 rdMask 5 wrMask 6 en 7 dis
  localparam int NROW = 21;
  localparam rowT TBL [NROW] = '{
    '{16'h0000, 3'd0, 16'h0000, 1'b0, 16'h0000, 1'b0, 16'h0400, 1'b0, 1'b0},
    '{16'h0000, 3'd5, 16'hFFFF, 1'b0, 16'h0000, 1'b0, 16'h0400, 1'b0, 1'b0},
    '{16'h0000, 3'd4, 16'h0000, 1'b0, 16'hFFFF, 1'b0, 16'h0400, 1'b0, 1'b0},
    '{16'h0000, 3'd6, 16'h0000, 1'b0, 16'h0000, 1'b0, 16'h0400, 1'b0, 1'b0},
    '{16'h0020, 3'd0, 16'h0000, 1'b0, 16'h0000, 1'b0, 16'h0400, 1'b1, 1'b0},
    '{16'h0000, 3'd1, 16'h0000, 1'b0, 16'h0020, 1'b1, 16'h0414, 1'b1, 1'b0},
    '{16'h0008, 3'd0, 16'h0000, 1'b1, 16'h0000, 1'b1, 16'h0414, 1'b1, 1'b1},
    '{16'h0000, 3'd1, 16'h0000, 1'b0, 16'h0028, 1'b0, 16'h0400, 1'b0, 1'b0},
    '{16'h0000, 3'd6, 16'h0000, 1'b0, 16'h0000, 1'b0, 16'h0400, 1'b0, 1'b0},
    '{16'h0000, 3'd0, 16'h0000, 1'b0, 16'h0000, 1'b1, 16'h040C, 1'b1, 1'b0},
    '{16'h0000, 3'd3, 16'h0008, 1'b0, 16'h0000, 1'b1, 16'h040C, 1'b1, 1'b0},
    '{16'h0000, 3'd5, 16'hFFDF, 1'b0, 16'h0000, 1'b1, 16'h0414, 1'b1, 1'b0},
    '{16'h0000, 3'd0, 16'h0000, 1'b0, 16'h0000, 1'b0, 16'h0400, 1'b1, 1'b0},
    '{16'h0000, 3'd7, 16'h0000, 1'b0, 16'h0000, 1'b0, 16'h0400, 1'b1, 1'b0},
    '{16'h0004, 3'd0, 16'h0000, 1'b0, 16'h0000, 1'b0, 16'h0400, 1'b0, 1'b0},
    '{16'h0000, 3'd0, 16'h0000, 1'b0, 16'h0000, 1'b1, 16'h0408, 1'b0, 1'b0},
    '{16'h0000, 3'd5, 16'h0000, 1'b0, 16'h0000, 1'b1, 16'h0408, 1'b0, 1'b0},
    '{16'h0001, 3'd0, 16'h0000, 1'b1, 16'h0000, 1'b1, 16'h0408, 1'b0, 1'b1},
    '{16'h0000, 3'd0, 16'h0000, 1'b0, 16'h0000, 1'b1, 16'h0400, 1'b0, 1'b0},
    '{16'h0000, 3'd2, 16'h0000, 1'b0, 16'h0000, 1'b1, 16'h0400, 1'b0, 1'b0},
    '{16'h0000, 3'd1, 16'h0000, 1'b0, 16'h0000, 1'b0, 16'h0400, 1'b0, 1'b0}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [15:0] e, input logic [2:0] o,
                      input logic [15:0] d, input logic t);
    @(negedge clk);
    evtPulse = e; cmdOp = o; cmdData = d; svcTake = t;
    #5;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    step(16'h0, 3'd1, 16'h0, 1'b0);
    chk("R1 pend", rdData, 16'h0000);
    chk("R1 status", statusWord, 16'h0000);
    chk("R1 req", {15'b0, svcReq}, 16'h0000);
    step(16'h0, 3'd4, 16'h0, 1'b0);
    chk("R1 mask", rdData, 16'h0000);

    // table walk: R2 R4 R5 R6 R7 R8 R9 R10
    for (int r = 0; r < NROW; r++) begin
      step(TBL[r].evt, TBL[r].op, TBL[r].data, TBL[r].take);
      chk($sformatf("R4 row%0d rd", r), rdData, TBL[r].expRd);
      chk($sformatf("R8 row%0d req", r), {15'b0, svcReq}, {15'b0, TBL[r].expReq});
      if (TBL[r].expReq)
        chk($sformatf("R8 row%0d vec", r), vecAddr, TBL[r].expVec);
      chk($sformatf("R2 row%0d en", r), {15'b0, statusWord[9]}, {15'b0, TBL[r].expEn});
      chk($sformatf("R9 row%0d save", r), {15'b0, saveIcStb}, {15'b0, TBL[r].expSave});
    end

    // R2: data ignored, exact status word
    step(16'h0, 3'd6, 16'h0000, 1'b0);
    step(16'h0, 3'd0, 16'h0, 1'b0);
    chk("R2 enable status", statusWord, 16'h0200);
    step(16'h0, 3'd7, 16'hFFFF, 1'b0);
    step(16'h0, 3'd0, 16'h0, 1'b0);
    chk("R2 disable status", statusWord, 16'h0000);

    // R5: clear and event on one bit, event wins
    step(16'h0080, 3'd0, 16'h0, 1'b0);
    step(16'h0080, 3'd3, 16'h0080, 1'b0);
    step(16'h0, 3'd1, 16'h0, 1'b0);
    chk("R5 clear vs event", rdData, 16'h0080);
    // R3: bit already set does not re-latch
    step(16'h0080, 3'd2, 16'h0000, 1'b0);
    step(16'h0, 3'd1, 16'h0, 1'b0);
    chk("R3 no relatch", rdData, 16'h0000);

    // R5 write, R6 masked source not serviced
    step(16'h0, 3'd2, 16'h1000, 1'b0);
    step(16'h0, 3'd1, 16'h0, 1'b0);
    chk("R5 write pend", rdData, 16'h1000);
    chk("R6 masked no req", {15'b0, svcReq}, 16'h0000);

    // R10: re-enable with pending set
    step(16'h0, 3'd5, 16'hFFFF, 1'b0);
    step(16'h0, 3'd6, 16'h0, 1'b0);
    chk("R10 before edge", {15'b0, svcReq}, 16'h0000);
    step(16'h0, 3'd0, 16'h0, 1'b0);
    chk("R10 req", {15'b0, svcReq}, 16'h0001);
    chk("R10 vec", vecAddr, 16'h0430);

    // R9: entry beats enable command
    step(16'h0, 3'd6, 16'h0, 1'b1);
    chk("R9 save", {15'b0, saveIcStb}, 16'h0001);
    step(16'h0, 3'd0, 16'h0, 1'b0);
    chk("R9 en cleared", statusWord, 16'h0000);
    chk("R9 no req", {15'b0, svcReq}, 16'h0000);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule